// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial side of a SPI controller running as bus master. It takes words from a transmit FIFO that sits next to it, shifts each one out on the data-out pin most significant bit first, samples the data-in pin during the same bit times, and pushes every completed received word into a receive FIFO. The serial clock comes from the system clock through a programmable divider. Clock idle level, the edge on which outgoing data changes, the point at which incoming data is sampled, and the word length of 8, 16 or 32 bits are all chosen by fields of a 32-bit control word.

The transmit FIFO is show-ahead: it presents its head word together with an empty flag, and the engine pulses a pop strobe in the cycle it takes that word. As long as the FIFO holds more words, they follow one another with no idle clock periods between them. An optional hardware chip select, active low, is driven while data is pending or in flight. Clearing the enable or the master bit, or choosing the reserved word-size code, stops the engine at once: the clock returns to its idle level and a partly shifted word is dropped.

Top module: `spim_engine`

## Requirements
- R1: Control bits 11:10 choose the word length: code 0 gives 8 bits, code 1 gives 16 bits, code 2 gives 32 bits. The word sits in the low bits of the transmit and receive data buses, and the unused upper receive bits read as zero.
- R2: With a 9-bit divider value D, one serial clock period lasts 2*(D+1) system clock cycles.
- R3: Control bit 6 sets the clock idle level: when it is 1, the serial clock rests high, and when it is 0, it rests low.
- R4: With control bit 8 set, outgoing data changes when the clock leaves its active level for idle; with it clear, outgoing data changes when the clock moves from idle to active. Either way a receiver that captures on the opposite edge sees every bit.
- R5: With control bit 9 clear, input data is sampled in the middle of each bit time, that is at the end of its first half; with it set, at the end of the bit time.
- R6: A word is taken from the FIFO only when control bit 15 (enable) and control bit 5 (master) are both 1 and the FIFO is not empty; otherwise no pop occurs and the clock stays idle.
- R7: With control bit 28 set, the chip select output is low while the FIFO is non-empty or a word is being shifted, and goes high once the last word has finished; with bit 28 clear, it stays high.
- R8: Data leaves and arrives most significant bit first.
- R9: When the FIFO still holds a word as one finishes, the next word starts with no idle clock time: N-bit words sent back to back at divider D take N*2*(D+1) cycles each.
- R10: If enable or master is cleared mid-word, the clock returns to its idle level in the next cycle, and no receive push happens for the abandoned word.
- R11: Word-size code 3 is reserved. While it is selected, no word is taken from the FIFO.
- R12: Each completed word gives exactly one single-cycle receive push, one cycle after its last bit time ends, and each word loaded gives exactly one pop.
- R13: The data-out pin is low whenever no word is being shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 32 | Control word (fields as in the requirements) |
| baud_div | input | 9 | Divider value D |
| tx_empty | input | 1 | Transmit FIFO holds no word |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_pop | output | 1 | Take the head word at this clock edge |
| rx_push | output | 1 | Received word valid on rx_data |
| rx_data | output | 32 | Received word, right-aligned |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Hardware chip select, active low |

## Verification
The finish of one word and the load of the next happen at the same clock edge when the FIFO still has data: the receive push for the old word and the pop for the new one share one cycle. The bench provokes this with three 16-bit words queued before enabling at divider zero. It then judges the result by the exact cycle distance from the first pop to the last push, which must equal three word times plus one, and by each received word and the serial stream captured from the data-out pin. Disabling the engine in the middle of a word is a second collision, between an abort and a bit in progress. Here the bench checks the idle clock level in the next cycle and the absence of any push afterwards.

// File: rtl/spim_pkg.sv
package spim_pkg;

   // control word field positions decoded by this engine
   localparam int unsigned POS_MST   = 5;
   localparam int unsigned POS_CPOL  = 6;
   localparam int unsigned POS_CKE   = 8;
   localparam int unsigned POS_SMP   = 9;
   localparam int unsigned POS_WSZ   = 10;
   localparam int unsigned POS_EN    = 15;
   localparam int unsigned POS_HWCS  = 28;

   typedef enum logic [1:0] {
      WSZ_8    = 2'd0,
      WSZ_16   = 2'd1,
      WSZ_32   = 2'd2,
      WSZ_RSVD = 2'd3
   } wsz_e;

   typedef struct packed {
      logic run;        // enable & master & legal word size
      logic cpol;       // idle level of the clock
      logic lead_hold;  // data changes on active->idle edge
      logic late_smp;   // sample at end of bit time
      logic hw_cs;      // hardware chip select requested
      wsz_e wsz;
   } cfg_t;

   function automatic logic [6:0] wsz_bits(wsz_e w);
      case (w)
         WSZ_8:   return 7'd8;
         WSZ_16:  return 7'd16;
         WSZ_32:  return 7'd32;
         default: return 7'd0;
      endcase
   endfunction

endpackage

// File: rtl/spim_cfg_dec.sv
module spim_cfg_dec
   import spim_pkg::*;
(
   input  logic [31:0] ctrl_word,
   output cfg_t        cfg
);
   wsz_e wsz;
   logic unused_ctrl_bits;

   assign wsz = wsz_e'(ctrl_word[POS_WSZ +: 2]);

   always_comb begin
      cfg.wsz       = wsz;
      cfg.cpol      = ctrl_word[POS_CPOL];
      cfg.lead_hold = ctrl_word[POS_CKE];
      cfg.late_smp  = ctrl_word[POS_SMP];
      cfg.hw_cs     = ctrl_word[POS_HWCS];
      cfg.run       = ctrl_word[POS_EN] & ctrl_word[POS_MST] & (wsz != WSZ_RSVD);
   end

   assign unused_ctrl_bits = ^{ctrl_word[31:29], ctrl_word[27:16],
                               ctrl_word[14:12], ctrl_word[7], ctrl_word[4:0]};
endmodule

// File: rtl/spim_baud_gen.sv
module spim_baud_gen #(
   parameter int unsigned DIV_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == div);
   assign tick   = active & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!active || at_end)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
   import spim_pkg::*;
#(
   parameter int unsigned MAX_WORD = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  cfg_t                cfg,
   input  logic                tick,
   input  logic                tx_empty,
   input  logic [MAX_WORD-1:0] tx_data,
   input  logic                miso,
   output logic                busy,
   output logic                tx_pop,
   output logic                rx_push,
   output logic [MAX_WORD-1:0] rx_data,
   output logic                sck,
   output logic                mosi
);
   localparam int unsigned CNT_W = $clog2(MAX_WORD);
   localparam int unsigned LEN_W = CNT_W + 1;

   logic                busy_q;
   logic                phase_q;   // 0: first half of bit, 1: second half
   logic [CNT_W-1:0]    bit_q;
   logic [MAX_WORD-1:0] tx_sr_q;
   logic [MAX_WORD-1:0] rx_sr_q;
   logic [MAX_WORD-1:0] rx_next;
   logic [MAX_WORD-1:0] load_val;
   logic [MAX_WORD-1:0] len_mask;
   logic [LEN_W-1:0]    nbits;
   logic [LEN_W-1:0]    shamt;
   logic                start;
   logic                last_bit;
   logic                word_end;
   logic                sample_now;

   assign nbits      = LEN_W'(wsz_bits(cfg.wsz));
   assign shamt      = LEN_W'(MAX_WORD) - nbits;
   assign load_val   = tx_data << shamt;
   assign len_mask   = {MAX_WORD{1'b1}} >> shamt;
   assign last_bit   = (bit_q == CNT_W'(nbits - 1'b1));
   assign start      = cfg.run & ~busy_q & ~tx_empty;
   assign word_end   = busy_q & tick & phase_q & last_bit;
   assign sample_now = busy_q & tick & (phase_q ? cfg.late_smp : ~cfg.late_smp);
   assign rx_next    = {rx_sr_q[MAX_WORD-2:0], miso};

   assign tx_pop = cfg.run & (start | (word_end & ~tx_empty));
   assign busy   = busy_q;
   assign sck    = busy_q ? (cfg.cpol ^ (cfg.lead_hold ? phase_q : ~phase_q)) : cfg.cpol;
   assign mosi   = busy_q & tx_sr_q[MAX_WORD-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         bit_q   <= '0;
         tx_sr_q <= '0;
         rx_sr_q <= '0;
         rx_push <= 1'b0;
         rx_data <= '0;
      end else if (!cfg.run) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         bit_q   <= '0;
         rx_push <= 1'b0;
      end else begin
         rx_push <= 1'b0;
         if (start) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            bit_q   <= '0;
            tx_sr_q <= load_val;
            rx_sr_q <= '0;
         end else if (busy_q && tick) begin
            if (sample_now)
               rx_sr_q <= rx_next;
            if (!phase_q) begin
               phase_q <= 1'b1;
            end else begin
               phase_q <= 1'b0;
               if (last_bit) begin
                  rx_push <= 1'b1;
                  rx_data <= (cfg.late_smp ? rx_next : rx_sr_q) & len_mask;
                  bit_q   <= '0;
                  if (!tx_empty) begin
                     tx_sr_q <= load_val;
                     rx_sr_q <= '0;
                  end else begin
                     busy_q <= 1'b0;
                  end
               end else begin
                  bit_q   <= bit_q + 1'b1;
                  tx_sr_q <= tx_sr_q << 1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/spim_cs_ctl.sv
module spim_cs_ctl
   import spim_pkg::*;
#(
   parameter bit HW_CS = 1'b1
) (
   input  cfg_t cfg,
   input  logic busy,
   input  logic tx_empty,
   output logic cs_n
);
   generate
      if (HW_CS) begin : g_hw
         assign cs_n = ~(cfg.hw_cs & cfg.run & (busy | ~tx_empty));
      end else begin : g_none
         logic unused_cs_in;
         assign unused_cs_in = ^{cfg, busy, tx_empty};
         assign cs_n = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/spim_engine.sv
module spim_engine
   import spim_pkg::*;
#(
   parameter int unsigned MAX_WORD = 32,
   parameter int unsigned DIV_W    = 9,
   parameter bit          HW_CS    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [31:0]         ctrl_word,
   input  logic [DIV_W-1:0]    baud_div,
   input  logic                tx_empty,
   input  logic [MAX_WORD-1:0] tx_data,
   output logic                tx_pop,
   output logic                rx_push,
   output logic [MAX_WORD-1:0] rx_data,
   input  logic                miso,
   output logic                sck,
   output logic                mosi,
   output logic                cs_n
);
   generate
      if (MAX_WORD != 32) begin : g_bad_word
         $error("spim_engine: MAX_WORD must be 32 to hold the widest word");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("spim_engine: DIV_W out of range");
      end
   endgenerate

   cfg_t cfg;
   logic tick;
   logic busy;

   spim_cfg_dec u_dec (
      .ctrl_word (ctrl_word),
      .cfg       (cfg)
   );

   spim_baud_gen #(.DIV_W(DIV_W)) u_baud (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (busy),
      .div    (baud_div),
      .tick   (tick)
   );

   spim_shifter #(.MAX_WORD(MAX_WORD)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg),
      .tick     (tick),
      .tx_empty (tx_empty),
      .tx_data  (tx_data),
      .miso     (miso),
      .busy     (busy),
      .tx_pop   (tx_pop),
      .rx_push  (rx_push),
      .rx_data  (rx_data),
      .sck      (sck),
      .mosi     (mosi)
   );

   spim_cs_ctl #(.HW_CS(HW_CS)) u_cs (
      .cfg      (cfg),
      .busy     (busy),
      .tx_empty (tx_empty),
      .cs_n     (cs_n)
   );
endmodule

// File: rtl/spim_engine_chk.sv
module spim_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] ctrl_word,
   input logic        tx_empty,
   input logic        tx_pop,
   input logic        rx_push,
   input logic        sck,
   input logic        cs_n
);
   logic run_c;
   assign run_c = ctrl_word[15] & ctrl_word[5] & (ctrl_word[11:10] != 2'b11);

   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !run_c |=> (sck == ctrl_word[6])); // R10

   AST_NO_PUSH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !run_c |=> !rx_push); // R10

   AST_CS_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_word[28] |-> cs_n); // R7

   AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> !rx_push); // R12

   AST_RSVD_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[11:10] == 2'b11) |-> !tx_pop); // R11

   AST_GATE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_word[15] && ctrl_word[5]) |-> !tx_pop); // R6

   AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> !tx_empty); // R6
endmodule

bind spim_engine spim_engine_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_word (ctrl_word),
   .tx_empty  (tx_empty),
   .tx_pop    (tx_pop),
   .rx_push   (rx_push),
   .sck       (sck),
   .cs_n      (cs_n)
);

// File: tb/spim_engine_bench.sv
module spim_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ctrl_word = '0;
   logic [8:0]  baud_div = '0;
   logic        tx_empty;
   logic [31:0] tx_data;
   logic        tx_pop, rx_push, sck, mosi, cs_n;
   logic [31:0] rx_data;
   logic        miso = 1'b0;

   always #5 clk = ~clk;

   spim_engine u_spim_engine (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .baud_div(baud_div),
      .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_data(rx_data), .miso(miso),
      .sck(sck), .mosi(mosi), .cs_n(cs_n)
   );

   // show-ahead transmit FIFO model
   logic [31:0] fmem [0:15];
   int unsigned wr_p = 0, rd_p = 0;
   assign tx_empty = (wr_p == rd_p);
   assign tx_data  = fmem[rd_p[3:0]];
   always @(posedge clk) if (tx_pop) rd_p <= rd_p + 1;

   int nchk = 0, nfail = 0;
   bit done = 0;

   // monitor / slave model
   int          cyc = 0, npop = 0, nrx = 0, first_pop = -1, last_push = 0;
   int          last_rise = 0, rise_gap = 0;
   logic [31:0] rxq [0:7];
   logic [127:0] sv = '0;
   logic [63:0] capt = '0;
   logic        lvl_h0 = 1'b0, seen_h1 = 1'b0, sck_q = 1'b0, pat_mode = 1'b0;
   logic        cs_low_seen = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (tx_pop) begin npop++; if (first_pop < 0) first_pop = cyc; end
      if (rx_push) begin rxq[nrx % 8] = rx_data; nrx++; last_push = cyc; end
      if (!cs_n) cs_low_seen = 1'b1;
      if (sck !== sck_q) begin
         if (sck && !sck_q) begin rise_gap = cyc - last_rise; last_rise = cyc; end
         if (sck != lvl_h0) begin capt = {capt[62:0], mosi}; seen_h1 = 1'b1; end
         else if (seen_h1) sv = {sv[126:0], 1'b0};
      end
      sck_q = sck;
      miso = pat_mode ? (sck == lvl_h0) : sv[127];
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_ctrl(bit en, bit mst, bit cpol, bit cke, bit smp,
                                           logic [1:0] wsz, bit hwcs);
      logic [31:0] c = '0;
      c[15] = en; c[5] = mst; c[6] = cpol; c[8] = cke; c[9] = smp;
      c[11:10] = wsz; c[28] = hwcs;
      return c;
   endfunction

   task automatic push_word(input logic [31:0] w);
      fmem[wr_p[3:0]] = w;
      wr_p = wr_p + 1;
   endtask

   // configure while stopped, reset slave state, then enable and queue words
   task automatic setup(input logic [31:0] c, input logic [8:0] d, input logic [127:0] slave,
                        input bit pat);
      @(negedge clk);
      ctrl_word = c & ~32'h0000_8000;
      baud_div  = d;
      repeat (2) @(negedge clk);
      lvl_h0 = c[8] ? c[6] : ~c[6];
      seen_h1 = 1'b0; capt = '0; sv = slave; pat_mode = pat;
      npop = 0; nrx = 0; first_pop = -1; cs_low_seen = 1'b0;
      miso = pat ? (sck == lvl_h0) : slave[127];
      @(negedge clk);
      ctrl_word = c;
   endtask

   task automatic wait_rx(input int n);
      int lim = 0;
      while (nrx < n && lim < 5000) begin @(negedge clk); lim++; end
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      check(sck == 1'b0, "R3 reset sck idle", sck, 0);
      check(cs_n == 1'b1, "R7 reset cs_n", cs_n, 1);
      check(mosi == 1'b0, "R13 reset mosi", mosi, 0);
      check(!tx_pop && !rx_push, "R12 reset strobes", {tx_pop, rx_push}, 0);
   endtask

   task automatic t_basic_8;
      setup(mk_ctrl(1,1,0,1,0,2'd0,0), 9'd1, {8'h3C, 120'h0}, 0);
      push_word(32'hFFFF_FFA5);
      wait_rx(1);
      check(rxq[0] == 32'h0000_003C, "R1 8-bit rx word", rxq[0], 32'h3C);
      check(capt[7:0] == 8'hA5, "R8 mosi msb first", capt[7:0], 8'hA5);
      check(npop == 1 && nrx == 1, "R12 one pop one push", {npop[15:0], nrx[15:0]}, 32'h0001_0001);
      check(mosi == 1'b0, "R13 mosi low after word", mosi, 0);
   endtask

   task automatic t_period;
      setup(mk_ctrl(1,1,0,1,0,2'd0,0), 9'd3, {8'h81, 120'h0}, 0);
      push_word(32'h0000_0055);
      wait_rx(1);
      check(rise_gap == 8, "R2 sck period at divider 3", rise_gap, 8);
      check(rxq[0] == 32'h81, "R2 data at divider 3", rxq[0], 32'h81);
   endtask

   task automatic t_cpol;
      setup(mk_ctrl(0,1,1,1,0,2'd0,0), 9'd1, '0, 0);
      @(negedge clk);
      check(sck == 1'b1, "R3 sck idles high", sck, 1);
      setup(mk_ctrl(1,1,1,1,0,2'd0,0), 9'd1, {8'hC3, 120'h0}, 0);
      push_word(32'h5A);
      wait_rx(1);
      check(rxq[0] == 32'hC3 && capt[7:0] == 8'h5A, "R3 transfer with high idle",
            {rxq[0], 24'h0, capt[7:0]}, {32'hC3, 32'h5A});
      check(sck == 1'b1, "R3 sck back high after word", sck, 1);
   endtask

   task automatic t_cke0;
      setup(mk_ctrl(1,1,0,0,0,2'd1,0), 9'd1, {16'hBEEF, 112'h0}, 0);
      push_word(32'hAAAA_1234);
      wait_rx(1);
      check(rxq[0] == 32'h0000_BEEF, "R4 R1 16-bit idle-to-active change", rxq[0], 32'hBEEF);
      check(capt[15:0] == 16'h1234, "R4 mosi with edge bit clear", capt[15:0], 16'h1234);
      setup(mk_ctrl(1,1,1,0,1,2'd2,0), 9'd0, {32'h8765_4321, 96'h0}, 0);
      push_word(32'hDEAD_BEEF);
      wait_rx(1);
      check(rxq[0] == 32'h8765_4321, "R4 R1 32-bit high idle", rxq[0], 32'h8765_4321);
      check(capt[31:0] == 32'hDEAD_BEEF, "R4 32-bit mosi", capt[31:0], 32'hDEAD_BEEF);
   endtask

   task automatic t_smp;
      setup(mk_ctrl(1,1,0,1,0,2'd0,0), 9'd1, '0, 1);
      push_word(32'h0F);
      wait_rx(1);
      check(rxq[0] == 32'hFF, "R5 middle sample", rxq[0], 32'hFF);
      setup(mk_ctrl(1,1,0,1,1,2'd0,0), 9'd1, '0, 1);
      push_word(32'h0F);
      wait_rx(1);
      check(rxq[0] == 32'h00, "R5 end sample", rxq[0], 32'h00);
   endtask

   task automatic t_b2b;
      setup(mk_ctrl(0,1,0,1,0,2'd1,0), 9'd0, {16'h1111, 16'h2222, 16'h3333, 80'h0}, 0);
      push_word(32'hA1B2); push_word(32'hC3D4); push_word(32'hE5F6);
      @(negedge clk);
      ctrl_word = mk_ctrl(1,1,0,1,0,2'd1,0);
      wait_rx(3);
      check(last_push - first_pop == 97, "R9 no gap between words", last_push - first_pop, 97);
      check(rxq[0] == 32'h1111 && rxq[1] == 32'h2222 && rxq[2] == 32'h3333,
            "R9 back-to-back rx words", {rxq[1], rxq[2]}, {32'h2222, 32'h3333});
      check(capt[47:0] == 48'hA1B2_C3D4_E5F6, "R9 back-to-back mosi", capt[47:0], 48'hA1B2C3D4E5F6);
      check(npop == 3 && nrx == 3, "R12 three pops three pushes", {npop[15:0], nrx[15:0]}, 32'h0003_0003);
   endtask

   task automatic t_cs;
      setup(mk_ctrl(1,1,0,1,0,2'd0,1), 9'd2, '0, 0);
      push_word(32'h11); push_word(32'h22);
      repeat (30) @(negedge clk);
      check(cs_n == 1'b0, "R7 cs low while words pending", cs_n, 0);
      wait_rx(2);
      check(cs_n == 1'b1, "R7 cs high after drain", cs_n, 1);
      setup(mk_ctrl(1,1,0,1,0,2'd0,0), 9'd2, '0, 0);
      push_word(32'h33);
      wait_rx(1);
      check(cs_low_seen == 1'b0, "R7 cs stays high without hw mode", cs_low_seen, 0);
   endtask

   task automatic t_disable;
      setup(mk_ctrl(1,1,1,1,0,2'd2,1), 9'd1, {32'hFFFF_FFFF, 96'h0}, 0);
      push_word(32'h8000_0001);
      repeat (20) @(negedge clk);
      ctrl_word = mk_ctrl(0,1,1,1,0,2'd2,1);
      @(negedge clk);
      check(sck == 1'b1 && mosi == 1'b0, "R10 R13 idle right after disable", {sck, mosi}, 2'b10);
      repeat (200) @(negedge clk);
      check(nrx == 0, "R10 no push for abandoned word", nrx, 0);
      ctrl_word = mk_ctrl(1,1,1,1,0,2'd2,1);
      repeat (20) @(negedge clk);
      check(cs_n == 1'b1 && nrx == 0 && npop == 1, "R10 re-enable with empty fifo stays idle",
            {cs_n, nrx[7:0]}, 9'h100);
   endtask

   task automatic t_gate;
      setup(mk_ctrl(1,0,0,1,0,2'd0,0), 9'd0, {8'h99, 120'h0}, 0);
      push_word(32'h66);
      repeat (100) @(negedge clk);
      check(npop == 0 && sck == 1'b0, "R6 no pop without master bit", npop, 0);
      ctrl_word = mk_ctrl(1,1,0,1,0,2'd0,0);
      wait_rx(1);
      check(rxq[0] == 32'h99 && npop == 1, "R6 starts once master set", rxq[0], 32'h99);
   endtask

   task automatic t_rsvd;
      setup(mk_ctrl(1,1,0,1,0,2'd3,0), 9'd0, {8'h5C, 120'h0}, 0);
      push_word(32'h77);
      repeat (100) @(negedge clk);
      check(npop == 0 && nrx == 0, "R11 reserved size takes no word", npop, 0);
      ctrl_word = mk_ctrl(1,1,0,1,0,2'd0,0);
      wait_rx(1);
      check(rxq[0] == 32'h5C, "R11 legal size resumes", rxq[0], 32'h5C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_basic_8;
      t_period;
      t_cpol;
      t_cke0;
      t_smp;
      t_b2b;
      t_cs;
      t_disable;
      t_gate;
      t_rsvd;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule